// File: doc/BRIEF.md
# Pushbutton Soft/Hard Reset Controller

This block turns a single active-low pushbutton into two kinds of reset request, chosen by how long the button is held. A short press produces a narrow active-low soft-reset pulse. The pulse appears only after the button has been let go and a debounce wait has passed. A press held beyond the long-press limit raises a hard-reset request while the button is still down. That request stays up until the button is released, and a downstream reset sequencer then adds its own release delay.

The raw button level passes through a synchronizer before any decision is taken. A saturating counter measures the press length in clock cycles. A second counter times the debounce wait and the soft pulse. A control state machine drives both counters through a small set of strobes. Every duration is a parameter counted in clock cycles. An idle input held high (the pulled-up, unpressed level) never triggers anything.

Top module: `button_reset_ctrl`

## Requirements
- R1: While the asynchronous reset `rstN` is low, and at once when it falls, `softResetN` is 1 and `hardResetReq` is 0. With `buttonN` held at 1 (not pressed), neither output ever changes.
- R2: A short press gives exactly one soft pulse, with `softResetN` low for exactly SOFT_CYCLES clock cycles.
- R3: Let r0 be the first rising edge that samples `buttonN` high after a short press. `softResetN` falls right after edge r0+DEBOUNCE_CYCLES+2: two synchronizer stages, one state step, then the debounce wait.
- R4: Let p0 be the first rising edge that samples `buttonN` low. A press sampled low on more than LONG_CYCLES consecutive edges raises `hardResetReq` right after edge p0+LONG_CYCLES+2.
- R5: `hardResetReq` stays at 1 while the button is held, and falls right after edge r0+2 following release.
- R6: The press-length boundary is exact. A press sampled low on exactly LONG_CYCLES edges counts as short and gives a soft pulse. A press sampled low on LONG_CYCLES+1 edges counts as long.
- R7: A long press produces no soft pulse, neither while held nor after release.
- R8: A press sampled low on a single rising edge is recognized as a short press and gives a soft pulse.
- R9: A new press that begins during the debounce wait or the soft pulse has no effect on either output, even if it is held past the long-press limit. The controller only accepts a new press once the pulse has ended and the button has been seen released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| buttonN | input | 1 | Raw pushbutton level, low when pressed |
| softResetN | output | 1 | Soft-reset pulse, active low |
| hardResetReq | output | 1 | Hard-reset request to the reset sequencer, active high |

## Verification
Two events can land in the same cycle. The first is release of the button on the very cycle the press counter reaches the long-press limit: the bench drives presses of exactly LONG_CYCLES and LONG_CYCLES+1 sampled edges and judges which output responds and when. The second is a new press arriving while the debounce wait or the soft pulse is running: the bench re-presses a few cycles after a release and holds past the long limit, then requires a single pulse timed from the first release and no hard request. Random press lengths around the limit are compared against cycle-exact expectations for pulse start, pulse width and hard-request edges.

// File: rtl/button_reset_pkg.sv
package button_reset_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRESSED,
    ST_DEBOUNCE,
    ST_SOFT,
    ST_HARD,
    ST_WAITREL
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pressLoad;
    logic pressInc;
    logic phaseClear;
    logic phaseInc;
  } dpCtl_t;

  // flags from datapath to control
  typedef struct packed {
    logic pressed;
    logic longHit;
    logic debDone;
    logic softDone;
  } dpStat_t;

endpackage

// File: rtl/button_reset_datapath.sv
module button_reset_datapath
  import button_reset_pkg::*;
#(
  parameter int LONG_CYCLES     = 500,
  parameter int DEBOUNCE_CYCLES = 50,
  parameter int SOFT_CYCLES     = 8,
  parameter int SYNC_STAGES     = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    buttonN,
  input  dpCtl_t  ctl,
  output dpStat_t stat
);

  localparam int PW       = $clog2(LONG_CYCLES + 1);
  localparam int PHMAX    = (DEBOUNCE_CYCLES > SOFT_CYCLES) ? DEBOUNCE_CYCLES : SOFT_CYCLES;
  localparam int PHW      = $clog2(PHMAX + 1);
  localparam logic [PW-1:0]  LONG_W = PW'(LONG_CYCLES);
  localparam logic [PHW-1:0] DEB_LAST  = PHW'(DEBOUNCE_CYCLES - 1);
  localparam logic [PHW-1:0] SOFT_LAST = PHW'(SOFT_CYCLES - 1);

  // synchronizer chain, reset to the released level
  logic [SYNC_STAGES-1:0] syncQ;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= buttonN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  logic pressedNow;
  assign pressedNow = ~syncQ[SYNC_STAGES-1];

  // press-length counter, saturating at the long limit
  logic [PW-1:0] pressCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pressCnt <= '0;
    end else if (ctl.pressLoad) begin
      pressCnt <= PW'(1);
    end else if (ctl.pressInc && (pressCnt < LONG_W)) begin
      pressCnt <= pressCnt + PW'(1);
    end
  end

  // phase counter shared by debounce wait and soft pulse
  logic [PHW-1:0] phaseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctl.phaseClear) begin
      phaseCnt <= '0;
    end else if (ctl.phaseInc) begin
      phaseCnt <= phaseCnt + PHW'(1);
    end
  end

  always_comb begin
    stat.pressed  = pressedNow;
    stat.longHit  = (pressCnt >= LONG_W);
    stat.debDone  = (phaseCnt == DEB_LAST);
    stat.softDone = (phaseCnt == SOFT_LAST);
  end

  // press counter never runs past the long limit
  assert_press_saturates_R4: assert property (@(posedge clk) disable iff (!rstN)
    pressCnt <= LONG_W);

  // phase counter never exceeds the longer of the two windows
  assert_phase_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt < PHW'(PHMAX));

endmodule

// File: rtl/button_reset_control.sv
module button_reset_control
  import button_reset_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    softResetN,
  output logic    hardResetReq
);

  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (stat.pressed) begin
          stateNext     = ST_PRESSED;
          ctl.pressLoad = 1'b1;
        end
      end
      ST_PRESSED: begin
        if (!stat.pressed) begin
          stateNext      = ST_DEBOUNCE;
          ctl.phaseClear = 1'b1;
        end else if (stat.longHit) begin
          stateNext = ST_HARD;
        end else begin
          ctl.pressInc = 1'b1;
        end
      end
      ST_DEBOUNCE: begin
        if (stat.debDone) begin
          stateNext      = ST_SOFT;
          ctl.phaseClear = 1'b1;
        end else begin
          ctl.phaseInc = 1'b1;
        end
      end
      ST_SOFT: begin
        if (stat.softDone) begin
          stateNext      = ST_WAITREL;
          ctl.phaseClear = 1'b1;
        end else begin
          ctl.phaseInc = 1'b1;
        end
      end
      ST_HARD: begin
        if (!stat.pressed) stateNext = ST_IDLE;
      end
      ST_WAITREL: begin
        if (!stat.pressed) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign softResetN   = (state != ST_SOFT);
  assign hardResetReq = (state == ST_HARD);

  // hard request only rises after a held press reached the limit
  assert_hard_needs_long_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hardResetReq) |-> ($past(stat.longHit) && $past(stat.pressed)));

  // hard request holds while the button stays down
  assert_hard_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hardResetReq && stat.pressed) |=> hardResetReq);

  // soft pulse starts only at the end of the debounce wait
  assert_soft_after_debounce_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(softResetN) |-> $past(stat.debDone));

  // leaving the hard state never yields a soft pulse
  assert_no_soft_after_hard_R7: assert property (@(posedge clk) disable iff (!rstN)
    hardResetReq |=> softResetN);

endmodule

// File: rtl/button_reset_ctrl.sv
module button_reset_ctrl
  import button_reset_pkg::*;
#(
  parameter int LONG_CYCLES     = 500,
  parameter int DEBOUNCE_CYCLES = 50,
  parameter int SOFT_CYCLES     = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic buttonN,
  output logic softResetN,
  output logic hardResetReq
);

  dpCtl_t  dpCtl;
  dpStat_t dpStat;

  button_reset_datapath #(
    .LONG_CYCLES    (LONG_CYCLES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .SOFT_CYCLES    (SOFT_CYCLES),
    .SYNC_STAGES    (2)
  ) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .buttonN(buttonN),
    .ctl    (dpCtl),
    .stat   (dpStat)
  );

  button_reset_control uControl (
    .clk         (clk),
    .rstN        (rstN),
    .stat        (dpStat),
    .ctl         (dpCtl),
    .softResetN  (softResetN),
    .hardResetReq(hardResetReq)
  );

endmodule

// File: tb/button_reset_ctrl_test.sv
module button_reset_ctrl_test;

  localparam int LONG = 40;
  localparam int DEB  = 12;
  localparam int SOFT = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic buttonN = 1'b1;
  logic softResetN, hardResetReq;

  button_reset_ctrl #(
    .LONG_CYCLES(LONG), .DEBOUNCE_CYCLES(DEB), .SOFT_CYCLES(SOFT)
  ) uut (
    .clk(clk), .rstN(rstN), .buttonN(buttonN),
    .softResetN(softResetN), .hardResetReq(hardResetReq)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  // output monitor, sampled at the falling edge
  logic prevSoft = 1'b1, prevHard = 1'b0;
  int softFalls, softFallCyc, softRiseCyc;
  int hardRises, hardRiseCyc, hardFallCyc;

  always @(negedge clk) begin
    if (prevSoft && !softResetN) begin softFalls++; softFallCyc = cyc; end
    if (!prevSoft && softResetN) softRiseCyc = cyc;
    if (!prevHard && hardResetReq) begin hardRises++; hardRiseCyc = cyc; end
    if (prevHard && !hardResetReq) hardFallCyc = cyc;
    prevSoft = softResetN;
    prevHard = hardResetReq;
  end

  task automatic clearMon();
    softFalls = 0; softFallCyc = -1; softRiseCyc = -1;
    hardRises = 0; hardRiseCyc = -1; hardFallCyc = -1;
  endtask

  task automatic cmp(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit isLong(int len);
    return len > LONG;
  endfunction

  task automatic doPress(int len);
    int p0, r0;
    clearMon();
    @(negedge clk);
    p0 = cyc + 1;
    buttonN = 1'b0;
    repeat (len) @(negedge clk);
    buttonN = 1'b1;
    r0 = cyc + 1;
    repeat (DEB + SOFT + 8) @(negedge clk);
    if (isLong(len)) begin
      cmp("R4 hard rise cycle", hardRiseCyc - p0, LONG + 2);
      cmp("R4 hard rise count", hardRises, 1);
      cmp("R5 hard fall after release", hardFallCyc - r0, 2);
      cmp("R7 no soft pulse on long press", softFalls, 0);
    end else begin
      cmp("R3 soft start after release", softFallCyc - r0, DEB + 2);
      cmp("R2 soft pulse width", softRiseCyc - softFallCyc, SOFT);
      cmp("R2 soft pulse count", softFalls, 1);
      cmp("R6 short press gives no hard", hardRises, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int r0;
    void'($urandom(32'd4711));
    clearMon();
    repeat (3) @(negedge clk);
    cmp("R1 soft idle in reset", int'(softResetN), 1);
    cmp("R1 hard idle in reset", int'(hardResetReq), 0);
    rstN = 1'b1;
    repeat (50) @(negedge clk);
    cmp("R1 no soft while released", softFalls, 0);
    cmp("R1 no hard while released", hardRises, 0);

    // directed corners
    doPress(1);          // R8 single sampled edge
    doPress(LONG);       // R6 boundary short
    doPress(LONG + 1);   // R6 boundary long
    doPress(3 * LONG);   // R5 long hold

    // R9: re-press during debounce, held past the long limit
    clearMon();
    @(negedge clk);
    buttonN = 1'b0;
    repeat (5) @(negedge clk);
    buttonN = 1'b1;
    r0 = cyc + 1;
    repeat (3) @(negedge clk);
    buttonN = 1'b0;
    repeat (2 * LONG + 5) @(negedge clk);
    buttonN = 1'b1;
    repeat (DEB + SOFT + 8) @(negedge clk);
    cmp("R9 single soft pulse", softFalls, 1);
    cmp("R9 pulse timed from first release", softFallCyc - r0, DEB + 2);
    cmp("R9 ignored press gives no hard", hardRises, 0);

    // R9: press starting inside the soft pulse
    clearMon();
    @(negedge clk);
    buttonN = 1'b0;
    repeat (4) @(negedge clk);
    buttonN = 1'b1;
    repeat (DEB + 4) @(negedge clk);
    buttonN = 1'b0;
    repeat (SOFT + 10) @(negedge clk);
    buttonN = 1'b1;
    repeat (DEB + SOFT + 8) @(negedge clk);
    cmp("R9 press in pulse ignored", softFalls, 1);
    cmp("R9 press in pulse no hard", hardRises, 0);

    // R1: asynchronous reset while hard request is up
    clearMon();
    @(negedge clk);
    buttonN = 1'b0;
    repeat (LONG + 6) @(negedge clk);
    cmp("R4 hard up before reset", int'(hardResetReq), 1);
    rstN = 1'b0;
    #1;
    cmp("R1 hard cleared by reset", int'(hardResetReq), 0);
    cmp("R1 soft idle by reset", int'(softResetN), 1);
    buttonN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    clearMon();
    repeat (DEB + SOFT + 8) @(negedge clk);
    cmp("R1 quiet after reset", softFalls + hardRises, 0);

    // random press lengths around the limit
    for (int i = 0; i < 24; i++) begin
      doPress(int'($urandom_range(1, 2 * LONG + 10)));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule